// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog that counts on its own slow, free-running clock, apart from the bus clock that software uses to program it. Software reaches it through a small write-only register port. A key register takes command bytes: one code starts the watchdog, one code refreshes it, and two codes unlock and lock the configuration. The configuration has a 3-bit prescaler field and an 8-bit reload value. Once the watchdog runs, a down-counter advances once per prescaled period. If software does not refresh the counter in time, the block raises a reset request pulse and sets a sticky cause flag.

The key writes and the configuration writes cross from the bus domain into the slow domain through a toggle handshake, so each write takes effect exactly once. The configuration is guarded twice. It must be unlocked, and the watchdog must already be running. Once the watchdog has started, no key write can stop it. Only the power-on reset returns it to idle.

Top module: `key_watchdog`

## Requirements
- R1: After power-on reset the watchdog is idle and locked, the prescaler is 0, the reload value is 0xFF, and both rst_req and wdg_flag are low.
- R2: The key code 0xCC, written to address 0, starts the watchdog. While the watchdog has not been started, rst_req never rises.
- R3: The key code 0xAA, written to address 0, reloads the counter from the reload value and restarts the prescale period. Refreshing more often than the timeout keeps rst_req low.
- R4: The key code 0x55 unlocks the configuration and 0x00 locks it. The lock state is kept whether or not the watchdog runs. While the configuration is unlocked and the watchdog runs, a write to address 1 sets the prescaler from wr_data[2:0], and a write to address 2 sets the reload value from wr_data[7:0].
- R5: A write to address 1 or 2 while locked, or before the watchdog is started, leaves the register unchanged.
- R6: After a refresh or a start, rst_req rises between (reload+1)·2^(p+3) and that many plus 6 slow-clock cycles later.
- R7: A prescaler field of 7 acts as 6.
- R8: rst_req stays high for exactly RST_LEN slow-clock cycles. At each expiry the counter reloads and keeps counting.
- R9: wdg_flag is set with each reset request and stays set until power-on reset.
- R10: No key write stops a running watchdog. Writing 0xCC while it runs does not reload the counter.
- R11: A key value other than 0xCC, 0xAA, 0x55 and 0x00 has no effect and does not change the lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register interface clock |
| slow_clk | input | 1 | Free-running watchdog clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| wr_en | input | 1 | Write strobe, one bus cycle per write |
| wr_addr | input | 2 | 0 key, 1 prescaler, 2 reload |
| wr_data | input | 8 | Write data |
| rst_req | output | 1 | Reset request pulse (slow domain) |
| wdg_flag | output | 1 | Sticky watchdog-reset cause flag |

## Verification
The assertions assume that the bus issues a new write only after the previous one has reached the slow domain. In practice this means writes at least three slow-clock cycles apart, so that the captured address and data stay stable while the toggle is synchronized. The stimulus follows this rule by waiting five slow-clock cycles after each write. The one exception is the single measured write that is left in flight while the bench counts slow cycles up to the reset request. Because the bench drives every write half a bus cycle away from the active edge, the toggle is never sampled at the instant it changes.

// File: rtl/key_watchdog.sv
module key_watchdog #(
  parameter int RST_LEN = 4
) (
  input  logic       bus_clk,
  input  logic       slow_clk,
  input  logic       por_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       rst_req,
  output logic       wdg_flag
);
  localparam int LW = $clog2(RST_LEN + 1);
  localparam int PW = 10;

  logic       cmd_tgl;
  logic [1:0] cmd_addr;
  logic [7:0] cmd_data;

  always_ff @(posedge bus_clk or negedge por_n)
    if (!por_n) begin
      cmd_tgl  <= 1'b0;
      cmd_addr <= '0;
      cmd_data <= '0;
    end else if (wr_en) begin
      cmd_tgl  <= ~cmd_tgl;
      cmd_addr <= wr_addr;
      cmd_data <= wr_data;
    end

  logic [2:0] sync;
  always_ff @(posedge slow_clk or negedge por_n)
    if (!por_n) sync <= '0;
    else        sync <= {sync[1:0], cmd_tgl};

  wire apply = sync[2] ^ sync[1];

  logic          running, unlocked;
  logic [2:0]    pre_r;
  logic [7:0]    reload_r, cnt;
  logic [PW-1:0] pre_cnt;
  logic [LW-1:0] len_cnt;

  wire is_key    = apply && cmd_addr == 2'd0;
  wire k_start   = is_key && cmd_data == 8'hCC;
  wire k_refresh = is_key && cmd_data == 8'hAA;
  wire k_unlock  = is_key && cmd_data == 8'h55;
  wire k_lock    = is_key && cmd_data == 8'h00;
  wire cfg_ok    = apply && unlocked && running;

  wire [2:0]    p_eff    = (pre_r > 3'd6) ? 3'd6 : pre_r;
  wire [PW-1:0] div_last = (PW'(8) << p_eff) - PW'(1);
  wire          tick     = running && pre_cnt >= div_last;
  wire          load     = (k_start && !running) || (k_refresh && running);
  wire          fire     = tick && cnt == 8'd0 && !load;

  always_ff @(posedge slow_clk or negedge por_n)
    if (!por_n) begin
      running  <= 1'b0;
      unlocked <= 1'b0;
      pre_r    <= 3'd0;
      reload_r <= 8'hFF;
    end else begin
      if (k_start)  running  <= 1'b1;
      if (k_unlock) unlocked <= 1'b1;
      else if (k_lock) unlocked <= 1'b0;
      if (cfg_ok && cmd_addr == 2'd1) pre_r    <= cmd_data[2:0];
      if (cfg_ok && cmd_addr == 2'd2) reload_r <= cmd_data;
    end

  always_ff @(posedge slow_clk or negedge por_n)
    if (!por_n) begin
      cnt     <= 8'hFF;
      pre_cnt <= '0;
    end else if (load) begin
      cnt     <= reload_r;
      pre_cnt <= '0;
    end else if (running) begin
      if (tick) begin
        pre_cnt <= '0;
        cnt     <= (cnt == 8'd0) ? reload_r : cnt - 8'd1;
      end else begin
        pre_cnt <= pre_cnt + PW'(1);
      end
    end

  always_ff @(posedge slow_clk or negedge por_n)
    if (!por_n) begin
      len_cnt  <= '0;
      wdg_flag <= 1'b0;
    end else begin
      if (fire) len_cnt <= LW'(RST_LEN);
      else if (len_cnt != '0) len_cnt <= len_cnt - LW'(1);
      if (fire) wdg_flag <= 1'b1;
    end

  assign rst_req = len_cnt != '0;

  AST_IDLE_QUIET:  assert property (@(posedge slow_clk) disable iff (!por_n)
                     !running |-> !rst_req);                                   // R2
  AST_CFG_GUARD:   assert property (@(posedge slow_clk) disable iff (!por_n)
                     !(apply && unlocked && running) |=> $stable(reload_r) && $stable(pre_r)); // R5
  AST_FLAG_WITH_RST: assert property (@(posedge slow_clk) disable iff (!por_n)
                     rst_req |-> wdg_flag);                                    // R9
  AST_FLAG_STICKY: assert property (@(posedge slow_clk) disable iff (!por_n)
                     wdg_flag |=> wdg_flag);                                   // R9
  AST_RUN_STICKY:  assert property (@(posedge slow_clk) disable iff (!por_n)
                     running |=> running);                                     // R10
endmodule

// File: tb/tb_key_watchdog.sv
module tb_key_watchdog;
  logic bus_clk = 0, slow_clk = 0, por_n = 0;
  logic wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic rst_req, wdg_flag;
  int checks = 0, fails = 0, pulses = 0;
  bit timed_out = 0;
  logic prev_rst = 0;

  always #10 bus_clk = ~bus_clk;
  always #40 slow_clk = ~slow_clk;

  key_watchdog #(.RST_LEN(4)) dut (.*);

  always @(posedge slow_clk) begin
    #2;
    if (rst_req && !prev_rst) pulses++;
    prev_rst = rst_req;
  end

  task automatic check(string req, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wait_slow(int n);
    repeat (n) @(posedge slow_clk);
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    @(negedge bus_clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge bus_clk);
    wr_en = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    bus_write(a, d);
    wait_slow(5);
  endtask

  task automatic measure(output int n);
    n = 0;
    while (n < 3000) begin
      @(posedge slow_clk); #1;
      n++;
      if (rst_req) break;
    end
  endtask

  task automatic timed_refresh(string req, int t);
    int n;
    bus_write(2'd0, 8'hAA);
    measure(n);
    check(req, n, t, t + 6);
    wait_slow(5);
  endtask

  task automatic t_reset();
    #1;
    check("R1 rst_req", rst_req, 0, 0);
    check("R1 wdg_flag", wdg_flag, 0, 0);
  endtask

  task automatic t_idle();
    int p0;
    p0 = pulses;
    wr(2'd0, 8'h55);
    wr(2'd2, 8'h03);
    wr(2'd1, 8'h05);
    wait_slow(3000);
    check("R2 no pulse while idle", pulses - p0, 0, 0);
    check("R2 flag idle", wdg_flag, 0, 0);
  endtask

  task automatic t_start_default();
    int n, w;
    bus_write(2'd0, 8'hCC);
    measure(n);
    check("R5/R6 default timeout", n, 2048, 2054);
    w = 0;
    while (rst_req) begin w++; @(posedge slow_clk); #1; end
    check("R8 pulse width", w, 4, 4);
    check("R9 flag set", wdg_flag, 1, 1);
  endtask

  task automatic t_config();
    wr(2'd0, 8'hAA);
    wr(2'd2, 8'h03);
    timed_refresh("R4 reload 3 p0", 32);
  endtask

  task automatic t_periodic();
    int p0;
    p0 = pulses;
    for (int i = 0; i < 30; i++) wr(2'd0, 8'hAA);
    wait_slow(5);
    check("R3 periodic refresh", pulses - p0, 0, 0);
  endtask

  task automatic t_prescale();
    wr(2'd0, 8'hAA);
    wr(2'd1, 8'h01);
    timed_refresh("R6 p1 timeout", 64);
  endtask

  task automatic t_lock();
    wr(2'd0, 8'hAA);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    timed_refresh("R5/R10 locked write ignored", 64);
  endtask

  task automatic t_bad_key();
    wr(2'd0, 8'hAA);
    wr(2'd0, 8'h12);
    wr(2'd1, 8'h00);
    timed_refresh("R11 bad key keeps lock", 64);
    wr(2'd0, 8'hAA);
    wr(2'd0, 8'h55);
    wr(2'd0, 8'h3C);
    wr(2'd1, 8'h00);
    timed_refresh("R11 bad key keeps unlock", 32);
  endtask

  task automatic t_clamp();
    wr(2'd0, 8'hAA);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h07);
    timed_refresh("R7 p7 acts as p6", 512);
  endtask

  task automatic t_restart();
    int n;
    wr(2'd0, 8'hAA);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h03);
    wr(2'd0, 8'hAA);
    bus_write(2'd0, 8'hAA);
    wait_slow(16);
    bus_write(2'd0, 8'hCC);
    measure(n);
    check("R10 start while running no reload", n + 16, 32, 39);
    wait_slow(5);
    check("R9 flag sticky", wdg_flag, 1, 1);
  endtask

  initial begin
    fork
      begin
        #5 t_reset();
        wait_slow(2);
        #3 por_n = 1;
        t_idle();
        t_start_default();
        t_config();
        t_periodic();
        t_prescale();
        t_lock();
        t_bad_key();
        t_clamp();
        t_restart();
      end
      begin
        repeat (150000) @(posedge bus_clk);
        timed_out = 1;
      end
    join_any
    if (timed_out) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule